// File: doc/BRIEF.md
# Quadrature Front End

This block conditions the two phase inputs and the index input of one encoder axis. It turns them into single-cycle count strobes with a direction flag, a single-cycle skip error, and index strobes for a separate position counter. Each raw input passes through a two-flop synchronizer. A glitch filter then samples it on ticks from a programmable prescaler that divides the filter clock by 1 to 256. A new level is taken only when two consecutive ticks agree on it.

The filtered phases drive a decoder state machine. Its four states track the filtered pair {A,B}: `PH_00`, `PH_10`, `PH_11` and `PH_01`. Each clock the decoder compares the present pair with its state and names the step:
- `STEP_HOLD` when nothing changed.
- `STEP_FWD` on the next state of the sequence 00→10→11→01→00, where A leads and the count goes up.
- `STEP_REV` on the previous state of that sequence, where B leads and the count goes down.
- `STEP_SKIP` when both phases changed at once.

A scaling select decides which steps produce a count: non-quadrature, X1, X2 or X4.

The filtered index has an enable and a polarity. It is steered to a load strobe, to a reset strobe, or to a count-enable gate.

Top module: `quad_front_end`

## Requirements
- R1: While `rst_n` is low and in the first cycles after it rises, all outputs are low, and the prescaler ratio is 1 (divisor 0).
- R2: A one-cycle pulse on `psc_load` stores `psc_value` = N. From then on, filter sample ticks occur every N+1 clocks. With N = 0 a 2-clock pulse on A passes the filter, and with N = 3 it does not.
- R3: A filtered input takes a new level only after two consecutive sample ticks see it. A pulse shorter than one tick period never reaches the decoder.
- R4: `scale_sel` = 2'b11 (X4): every `STEP_FWD` gives a count with `count_down` = 0, and every `STEP_REV` gives a count with `count_down` = 1. That is four counts per full A/B cycle.
- R5: `scale_sel` = 2'b10 (X2): only steps in which A changes give a count. That is two per cycle, with direction as in R4.
- R6: `scale_sel` = 2'b01 (X1): one count per cycle. An up count comes on the 00→10 step and a down count on the 10→00 step.
- R7: `scale_sel` = 2'b00 (non-quadrature): each filtered rising edge of A gives one count, with `count_down` equal to the filtered B level (high = down). B edges give no count, and `skip_error` stays low.
- R8: In the three quadrature scalings, a `STEP_SKIP` gives a one-cycle `skip_error` and no count.
- R9: While `ab_enable` is low no count strobe appears, but the state keeps tracking the phases.
- R10: With `index_enable` = 1, a strobe fires for one clock on the filtered index edge into the active level: rising edge for `index_polarity` = 1, falling edge for 0. With `index_enable` = 0 no index strobe appears.
- R11: `index_route` = 0 sends the strobe to `load_strobe`. `index_route` = 1 with `gate_sel` = 0 sends it to `reset_strobe`.
- R12: With `index_enable`, `index_route` and `gate_sel` all 1, no index strobe fires, and counts pass only while the filtered index is at its active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Raw phase A |
| phase_b | input | 1 | Raw phase B |
| index_raw | input | 1 | Raw index |
| psc_load | input | 1 | Load prescaler divisor |
| psc_value | input | 8 | Divisor N, ratio N+1 |
| ab_enable | input | 1 | Allow count strobes |
| scale_sel | input | 2 | 00 non-quad, 01 X1, 10 X2, 11 X4 |
| index_enable | input | 1 | Enable index functions |
| index_polarity | input | 1 | 1 active high, 0 active low |
| index_route | input | 1 | 0 load path, 1 reset/gate path |
| gate_sel | input | 1 | On reset/gate path: 0 reset strobe, 1 count gate |
| count_pulse | output | 1 | One-cycle count strobe |
| count_down | output | 1 | Direction of the latest count, 1 = down |
| skip_error | output | 1 | One-cycle skipped-state error |
| load_strobe | output | 1 | Index strobe, load path |
| reset_strobe | output | 1 | Index strobe, reset path |

## Verification
The decoder is tried with full forward and full reverse cycles in each scaling. This separates X4, X2 and X1 by the number and position of the counts, and shows that direction follows which phase leads. Simultaneous changes of both phases separate the skip error in the quadrature scalings from the non-quadrature rule, where the same change is harmless and only A's rising edge with B's level matters. Short pulses on A, first with a divisor of 0 and then 3, show that the prescaler and the two-tick rule both shape what survives. Index edges of both polarities under each routing show which strobe fires, and the gate case shows counts held back and then released.

// File: rtl/qfe_pkg.sv
package qfe_pkg;
    localparam int DIV_W  = 8;
    localparam int SYNC_N = 2;
    localparam int IN_W   = 3;

    typedef enum logic [1:0] {
        SCALE_NQ = 2'b00,
        SCALE_X1 = 2'b01,
        SCALE_X2 = 2'b10,
        SCALE_X4 = 2'b11
    } scale_e;

    // encoding is {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_e;

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_FWD,
        STEP_REV,
        STEP_SKIP
    } step_e;

    function automatic step_e classify(input phase_e cur, input logic [1:0] nxt);
        phase_e fwd, rev;
        unique case (cur)
            PH_00: begin fwd = PH_10; rev = PH_01; end
            PH_10: begin fwd = PH_11; rev = PH_00; end
            PH_11: begin fwd = PH_01; rev = PH_10; end
            PH_01: begin fwd = PH_00; rev = PH_11; end
        endcase
        if (nxt == cur)      return STEP_HOLD;
        else if (nxt == fwd) return STEP_FWD;
        else if (nxt == rev) return STEP_REV;
        else                 return STEP_SKIP;
    endfunction
endpackage

// File: rtl/qfe_prescaler.sv
module qfe_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            div_q <= div_in;
            cnt_q <= div_in;
        end else if (tick) begin
            cnt_q <= div_q;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/qfe_filter.sv
module qfe_filter #(
    parameter int W    = 3,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] raw,
    output logic [W-1:0] filt
);
    logic [W-1:0] sync_q [SYNC];
    logic [W-1:0] synced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC; i++) sync_q[i] <= '0;
        end else begin
            sync_q[0] <= raw;
            for (int i = 1; i < SYNC; i++) sync_q[i] <= sync_q[i-1];
        end
    end

    assign synced = sync_q[SYNC-1];

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic cand_q;
        logic level_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cand_q  <= 1'b0;
                level_q <= 1'b0;
            end else if (tick) begin
                cand_q <= synced[g];
                if (synced[g] == cand_q && synced[g] != level_q)
                    level_q <= synced[g];
            end
        end
        assign filt[g] = level_q;
    end
endmodule

// File: rtl/qfe_decoder.sv
module qfe_decoder
    import qfe_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   a_f,
    input  logic   b_f,
    input  scale_e scale,
    input  logic   count_ok,
    output logic   count_pulse,
    output logic   count_down,
    output logic   skip_error
);
    phase_e state_q;
    step_e  step;
    logic   hit, dir_down, err;
    logic   a_moved;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_00;
        else        state_q <= phase_e'({a_f, b_f});
    end

    always_comb begin
        step     = classify(state_q, {a_f, b_f});
        a_moved  = (state_q[1] != a_f);
        hit      = 1'b0;
        dir_down = (step == STEP_REV);
        err      = 1'b0;
        unique case (scale)
            SCALE_NQ: begin
                hit      = !state_q[1] && a_f;
                dir_down = b_f;
            end
            SCALE_X1: begin
                hit = (step == STEP_FWD && state_q == PH_00) ||
                      (step == STEP_REV && state_q == PH_10);
                err = (step == STEP_SKIP);
            end
            SCALE_X2: begin
                hit = (step == STEP_FWD || step == STEP_REV) && a_moved;
                err = (step == STEP_SKIP);
            end
            SCALE_X4: begin
                hit = (step == STEP_FWD || step == STEP_REV);
                err = (step == STEP_SKIP);
            end
        endcase
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_pulse <= 1'b0;
            count_down  <= 1'b0;
            skip_error  <= 1'b0;
        end else begin
            count_pulse <= hit && count_ok;
            skip_error  <= err;
            if (hit && count_ok) count_down <= dir_down;
        end
    end
endmodule

// File: rtl/qfe_index_route.sv
module qfe_index_route (
    input  logic clk,
    input  logic rst_n,
    input  logic idx_f,
    input  logic enable,
    input  logic polarity,
    input  logic route,
    input  logic gate_sel,
    output logic gate_open,
    output logic load_strobe,
    output logic reset_strobe
);
    logic idx_q;
    logic act_edge;
    logic gate_mode;

    assign gate_mode = enable && route && gate_sel;
    assign gate_open = !gate_mode || (polarity ? idx_f : !idx_f);
    assign act_edge  = polarity ? (idx_f && !idx_q) : (!idx_f && idx_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q        <= 1'b0;
            load_strobe  <= 1'b0;
            reset_strobe <= 1'b0;
        end else begin
            idx_q        <= idx_f;
            load_strobe  <= enable && !route && act_edge;
            reset_strobe <= enable && route && !gate_sel && act_edge;
        end
    end
endmodule

// File: rtl/quad_front_end.sv
module quad_front_end
    import qfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             index_raw,
    input  logic             psc_load,
    input  logic [DIV_W-1:0] psc_value,
    input  logic             ab_enable,
    input  logic [1:0]       scale_sel,
    input  logic             index_enable,
    input  logic             index_polarity,
    input  logic             index_route,
    input  logic             gate_sel,
    output logic             count_pulse,
    output logic             count_down,
    output logic             skip_error,
    output logic             load_strobe,
    output logic             reset_strobe
);
    logic            tick;
    logic [IN_W-1:0] filt;
    logic            gate_open;

    qfe_prescaler #(.DIV_W(DIV_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .load(psc_load), .div_in(psc_value), .tick(tick)
    );

    qfe_filter #(.W(IN_W), .SYNC(SYNC_N)) u_flt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .raw({index_raw, phase_b, phase_a}), .filt(filt)
    );

    qfe_index_route u_idx (
        .clk(clk), .rst_n(rst_n), .idx_f(filt[2]),
        .enable(index_enable), .polarity(index_polarity),
        .route(index_route), .gate_sel(gate_sel),
        .gate_open(gate_open), .load_strobe(load_strobe), .reset_strobe(reset_strobe)
    );

    qfe_decoder u_dec (
        .clk(clk), .rst_n(rst_n), .a_f(filt[0]), .b_f(filt[1]),
        .scale(scale_e'(scale_sel)), .count_ok(ab_enable && gate_open),
        .count_pulse(count_pulse), .count_down(count_down), .skip_error(skip_error)
    );
endmodule

// File: rtl/qfe_checker.sv
module qfe_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ab_enable,
    input logic [1:0] scale_sel,
    input logic       index_enable,
    input logic       index_route,
    input logic       gate_sel,
    input logic       count_pulse,
    input logic       skip_error,
    input logic       load_strobe,
    input logic       reset_strobe
);
    // R9
    no_count_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_enable |=> !count_pulse);
    // R8
    skip_without_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(skip_error && count_pulse));
    // R7
    nq_no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scale_sel == 2'b00) |=> !skip_error);
    // R10
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_strobe |=> !load_strobe);
    // R10
    reset_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_strobe |=> !reset_strobe);
    // R10
    index_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !index_enable |=> !(load_strobe || reset_strobe));
    // R11
    load_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) || !load_strobe || $past(!index_route));
    // R12
    gate_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (index_enable && index_route && gate_sel) |=> !(load_strobe || reset_strobe));
endmodule

bind quad_front_end qfe_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ab_enable(ab_enable), .scale_sel(scale_sel),
    .index_enable(index_enable), .index_route(index_route), .gate_sel(gate_sel),
    .count_pulse(count_pulse), .skip_error(skip_error),
    .load_strobe(load_strobe), .reset_strobe(reset_strobe)
);

// File: tb/quad_front_end_tb_top.sv
module quad_front_end_tb_top;
    localparam int HOLD = 24;
    localparam int EV_UP = 0, EV_DN = 1, EV_ERR = 2, EV_LD = 3, EV_RS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase_a = 0, phase_b = 0, index_raw = 0, psc_load = 0;
    logic [7:0] psc_value = 8'd0;
    logic ab_enable = 0, index_enable = 0, index_polarity = 0, index_route = 0, gate_sel = 0;
    logic [1:0] scale_sel = 2'b11;
    logic count_pulse, count_down, skip_error, load_strobe, reset_strobe;

    typedef struct { int code; string req; } ev_t;
    ev_t exp_q[$];
    int checks = 0, fails = 0, ev_seen = 0;
    string cur_req = "R1";
    bit done = 0;

    always #5 clk = ~clk;

    quad_front_end dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_ev(input int code, input string req);
        ev_t e;
        e.code = code; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic drive_ab(input bit a, input bit b);
        wait_clk(1);
        phase_a = a; phase_b = b;
        wait_clk(HOLD);
    endtask

    task automatic drive_idx(input bit v);
        wait_clk(1);
        index_raw = v;
        wait_clk(HOLD);
    endtask

    task automatic pulse_a(input int len);
        wait_clk(1);
        phase_a = 1'b1;
        wait_clk(len);
        phase_a = 1'b0;
        wait_clk(HOLD);
    endtask

    task automatic got(input int code);
        ev_t e;
        ev_seen++;
        if (exp_q.size() == 0) begin
            chk(0, cur_req, code, -1);
        end else begin
            e = exp_q.pop_front();
            chk(code == e.code, e.req, code, e.code);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (count_pulse) got(count_down ? EV_DN : EV_UP);
            if (skip_error)   got(EV_ERR);
            if (load_strobe)  got(EV_LD);
            if (reset_strobe) got(EV_RS);
        end
    end

    initial begin
        #(10 * 150000);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int snap;
        // R1 reset state
        wait_clk(5);
        chk({count_pulse, skip_error, load_strobe, reset_strobe} == 4'b0, "R1",
            {count_pulse, skip_error, load_strobe, reset_strobe}, 0);
        rst_n = 1'b1;
        wait_clk(4);
        chk({count_pulse, skip_error, load_strobe, reset_strobe} == 4'b0, "R1",
            {count_pulse, skip_error, load_strobe, reset_strobe}, 0);
        ab_enable = 1'b1;

        // R4 X4 forward and reverse
        cur_req = "R4"; scale_sel = 2'b11;
        expect_ev(EV_UP, "R4"); drive_ab(1, 0);
        expect_ev(EV_UP, "R4"); drive_ab(1, 1);
        expect_ev(EV_UP, "R4"); drive_ab(0, 1);
        expect_ev(EV_UP, "R4"); drive_ab(0, 0);
        expect_ev(EV_DN, "R4"); drive_ab(0, 1);
        expect_ev(EV_DN, "R4"); drive_ab(1, 1);
        expect_ev(EV_DN, "R4"); drive_ab(1, 0);
        expect_ev(EV_DN, "R4"); drive_ab(0, 0);

        // R5 X2
        cur_req = "R5"; scale_sel = 2'b10;
        expect_ev(EV_UP, "R5"); drive_ab(1, 0);
        drive_ab(1, 1);
        expect_ev(EV_UP, "R5"); drive_ab(0, 1);
        drive_ab(0, 0);
        drive_ab(0, 1);
        expect_ev(EV_DN, "R5"); drive_ab(1, 1);
        drive_ab(1, 0);
        expect_ev(EV_DN, "R5"); drive_ab(0, 0);

        // R6 X1
        cur_req = "R6"; scale_sel = 2'b01;
        expect_ev(EV_UP, "R6"); drive_ab(1, 0);
        drive_ab(1, 1); drive_ab(0, 1); drive_ab(0, 0);
        drive_ab(0, 1); drive_ab(1, 1); drive_ab(1, 0);
        expect_ev(EV_DN, "R6"); drive_ab(0, 0);

        // R8 skipped state
        cur_req = "R8"; scale_sel = 2'b11;
        expect_ev(EV_ERR, "R8"); drive_ab(1, 1);
        expect_ev(EV_ERR, "R8"); drive_ab(0, 0);

        // R9 enable off, state still tracks
        cur_req = "R9"; ab_enable = 1'b0; snap = ev_seen;
        drive_ab(1, 0); drive_ab(1, 1); drive_ab(0, 1); drive_ab(0, 0);
        chk(ev_seen == snap, "R9", ev_seen - snap, 0);
        ab_enable = 1'b1;
        expect_ev(EV_UP, "R9"); drive_ab(1, 0);
        expect_ev(EV_DN, "R9"); drive_ab(0, 0);

        // R7 non-quadrature
        cur_req = "R7"; scale_sel = 2'b00;
        drive_ab(0, 1);
        expect_ev(EV_DN, "R7"); drive_ab(1, 1);
        drive_ab(0, 1);
        drive_ab(0, 0);
        expect_ev(EV_UP, "R7"); drive_ab(1, 0);
        drive_ab(0, 1);
        drive_ab(0, 0);

        // R2 / R3 prescaler and filter
        cur_req = "R2"; scale_sel = 2'b11;
        expect_ev(EV_UP, "R2"); expect_ev(EV_DN, "R2"); pulse_a(2);
        cur_req = "R3"; snap = ev_seen;
        pulse_a(1);
        chk(ev_seen == snap, "R3", ev_seen - snap, 0);
        wait_clk(1); psc_value = 8'd3; psc_load = 1'b1;
        wait_clk(1); psc_load = 1'b0;
        wait_clk(HOLD);
        cur_req = "R2"; snap = ev_seen;
        pulse_a(2);
        chk(ev_seen == snap, "R2", ev_seen - snap, 0);
        expect_ev(EV_UP, "R3"); drive_ab(1, 0);
        expect_ev(EV_DN, "R3"); drive_ab(0, 0);

        // R10 / R11 index polarity and routing
        cur_req = "R11"; index_enable = 1'b1; index_polarity = 1'b1; index_route = 1'b0;
        expect_ev(EV_LD, "R11"); drive_idx(1);
        drive_idx(0);
        cur_req = "R10"; index_polarity = 1'b0;
        drive_idx(1);
        expect_ev(EV_LD, "R10"); drive_idx(0);
        cur_req = "R11"; index_polarity = 1'b1; index_route = 1'b1; gate_sel = 1'b0;
        expect_ev(EV_RS, "R11"); drive_idx(1);
        drive_idx(0);
        cur_req = "R10"; index_enable = 1'b0; snap = ev_seen;
        drive_idx(1); drive_idx(0);
        chk(ev_seen == snap, "R10", ev_seen - snap, 0);

        // R12 gate mode
        cur_req = "R12"; index_enable = 1'b1; gate_sel = 1'b1; snap = ev_seen;
        drive_ab(1, 0); drive_ab(0, 0);
        drive_idx(1);
        chk(ev_seen == snap, "R12", ev_seen - snap, 0);
        expect_ev(EV_UP, "R12"); drive_ab(1, 0);
        expect_ev(EV_DN, "R12"); drive_ab(0, 0);
        drive_idx(0);

        wait_clk(HOLD);
        chk(exp_q.size() == 0, "R4", exp_q.size(), 0);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule